// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block decides how a CAN channel leaves the bus-off state. It watches the sampled bus bits and counts completed runs of eleven recessive bits while the channel is bus-off. After the required number of runs it ends bus-off. It also owns the channel mode (operating, reset, halt) and applies CPU requests to change that mode.

A 2-bit recovery policy, writable only in reset mode, selects one of four behaviours:
- standard recovery back to operating, with an optional deferred halt;
- halt as soon as bus-off is entered;
- halt once recovery completes;
- halt on a CPU request made during bus-off.

The policy also decides whether a recovery interrupt pulse is raised. Every exit from bus-off except one forced by the reset request gives a one-cycle pulse that clears the external transmit and receive error counters.

Top module: `can_busoff_ctrl`

## Requirements
- R1: After hardware reset the channel mode is reset (`chan_mode_o` = 2'b01), `busoff_o` is 0, and `recov_irq_o` and `err_clr_o` are 0. Mode codes are 2'b00 operating, 2'b01 reset and 2'b10 halt.
- R2: A write of `rec_mode_i` (strobed by `rec_mode_we_i`) is taken only while the mode is reset. A write in any other mode leaves the old policy in force.
- R3: When the channel is not bus-off, requests take effect one cycle later, in this priority: `reset_req_i` gives reset, `halt_req_i` gives halt, and `run_req_i` gives operating.
- R4: A `busoff_enter_i` pulse while operating and not bus-off sets `busoff_o` in the next cycle under policies 00, 10 and 11. The mode stays operating.
- R5: Bus-off ends only after 128 completed runs of 11 consecutive recessive sampled bits (`bit_lvl_i`=1 is recessive). A dominant sample restarts the current run. Each completed run restarts counting at the following bit.
- R6: Policy 00: at recovery `busoff_o` falls and `recov_irq_o` and `err_clr_o` pulse. The mode becomes operating. A halt request made during bus-off is held, and the mode becomes halt at recovery instead.
- R7: Policy 01: bus-off entry moves the mode to halt at once. `err_clr_o` pulses, `recov_irq_o` stays 0 and `busoff_o` stays 0.
- R8: Policy 10: at recovery the mode becomes halt, and `recov_irq_o` and `err_clr_o` pulse.
- R9: Policy 11: a halt request during bus-off ends bus-off and moves the mode to halt in the next cycle. `err_clr_o` pulses and `recov_irq_o` does not.
- R10: Policy 11: if recovery completes with no halt request, `recov_irq_o` and `err_clr_o` pulse and the mode stays operating.
- R11: A reset request in the same cycle as an automatic halt (entry under 01, recovery end under 10) wins. The mode becomes reset, `busoff_o` is 0, and neither pulse is raised.
- R12: `recov_irq_o` and `err_clr_o` are single-cycle pulses.
- R13: The run and occurrence counts are cleared on bus-off entry and on every exit from bus-off. A later bus-off again needs all 128 runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Sampled-bit strobe |
| bit_lvl_i | input | 1 | Sampled bus level, 1 = recessive |
| busoff_enter_i | input | 1 | Bus-off entry pulse |
| rec_mode_i | input | 2 | Recovery policy write data |
| rec_mode_we_i | input | 1 | Recovery policy write strobe |
| halt_req_i | input | 1 | CPU halt request |
| reset_req_i | input | 1 | CPU reset request |
| run_req_i | input | 1 | CPU operate request |
| chan_mode_o | output | 2 | Channel mode: 00 operating, 01 reset, 10 halt |
| busoff_o | output | 1 | Bus-off flag |
| recov_irq_o | output | 1 | Recovery interrupt pulse |
| err_clr_o | output | 1 | Error counter clear pulse |

## Verification
The CPU reset request can land in the same cycle as an automatic halt. Under policy 10 that halt comes from the 128th completed recessive run; under policy 01 it comes from the entry pulse. The bench raises the reset request exactly in the cycle after the last recessive bit is strobed, and in a second case together with the entry pulse. The outcome is judged as reset mode with bus-off clear and no interrupt or clear pulse.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;
  typedef enum logic [1:0] {
    CH_OPER  = 2'b00,
    CH_RESET = 2'b01,
    CH_HALT  = 2'b10
  } ch_mode_e;

  typedef enum logic [1:0] {
    BOR_STD       = 2'b00,
    BOR_HALT_IN   = 2'b01,
    BOR_HALT_OUT  = 2'b10,
    BOR_HALT_CPU  = 2'b11
  } bor_pol_e;
endpackage

// File: rtl/can_bor_run_cnt.sv
module can_bor_run_cnt #(
  parameter int unsigned RUN_LEN = 11,
  localparam int unsigned CW = $clog2(RUN_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_vld_i,
  input  logic bit_lvl_i,
  output logic run_done_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == CW'(RUN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      run_done_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q      <= '0;
      run_done_o <= 1'b0;
    end else begin
      run_done_o <= 1'b0;
      if (bit_vld_i) begin
        if (!bit_lvl_i) begin
          cnt_q <= '0;          // dominant restarts the run
        end else if (last) begin
          cnt_q      <= '0;
          run_done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r5_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(RUN_LEN));
  a_r5_done_on_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_done_o) |-> $past(bit_vld_i && bit_lvl_i && en_i));
  a_r13_run_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !run_done_o);
endmodule

// File: rtl/can_bor_occ_cnt.sv
module can_bor_occ_cnt #(
  parameter int unsigned OCC_LEN = 128,
  localparam int unsigned OW = $clog2(OCC_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_done_i,
  output logic recov_done_o
);
  logic [OW-1:0] occ_q;
  logic          term;

  assign term         = (occ_q == OW'(OCC_LEN - 1));
  assign recov_done_o = en_i && run_done_i && term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          occ_q <= '0;
    else if (!en_i)       occ_q <= '0;
    else if (run_done_i)  occ_q <= term ? '0 : occ_q + 1'b1;
  end

  a_r13_occ_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> occ_q == '0);
  a_r5_done_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_done_o |-> en_i);
endmodule

// File: rtl/can_bor_mode_fsm.sv
module can_bor_mode_fsm
  import can_bor_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busoff_enter_i,
  input  logic       recov_done_i,
  input  logic [1:0] rec_mode_i,
  input  logic       rec_mode_we_i,
  input  logic       halt_req_i,
  input  logic       reset_req_i,
  input  logic       run_req_i,
  output ch_mode_e   mode_o,
  output logic       busoff_o,
  output logic       recov_irq_o,
  output logic       err_clr_o
);
  bor_pol_e pol_q;
  ch_mode_e mode_n;
  logic     bo_n, irq_n, clr_n, pend_q, pend_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              pol_q <= BOR_STD;
    else if (rec_mode_we_i && mode_o == CH_RESET) pol_q <= bor_pol_e'(rec_mode_i);
  end

  always_comb begin
    mode_n = mode_o;
    bo_n   = busoff_o;
    irq_n  = 1'b0;
    clr_n  = 1'b0;
    pend_n = pend_q;
    if (reset_req_i) begin
      mode_n = CH_RESET;
      bo_n   = 1'b0;
      pend_n = 1'b0;
    end else if (busoff_o) begin
      if (recov_done_i) begin
        bo_n   = 1'b0;
        clr_n  = 1'b1;
        irq_n  = (pol_q != BOR_HALT_IN);
        mode_n = (pol_q == BOR_HALT_OUT || pend_q) ? CH_HALT : CH_OPER;
        pend_n = 1'b0;
      end else if (halt_req_i) begin
        if (pol_q == BOR_HALT_CPU) begin
          bo_n   = 1'b0;
          clr_n  = 1'b1;
          mode_n = CH_HALT;
        end else begin
          pend_n = 1'b1;        // deferred to recovery end
        end
      end
    end else if (mode_o == CH_OPER && busoff_enter_i) begin
      if (pol_q == BOR_HALT_IN) begin
        mode_n = CH_HALT;
        clr_n  = 1'b1;
      end else begin
        bo_n = 1'b1;
      end
    end else if (halt_req_i) begin
      mode_n = CH_HALT;
    end else if (run_req_i) begin
      mode_n = CH_OPER;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= CH_RESET;
      busoff_o    <= 1'b0;
      recov_irq_o <= 1'b0;
      err_clr_o   <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      mode_o      <= mode_n;
      busoff_o    <= bo_n;
      recov_irq_o <= irq_n;
      err_clr_o   <= clr_n;
      pend_q      <= pend_n;
    end
  end

  a_r12_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_irq_o |=> !recov_irq_o);
  a_r12_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_o |=> !err_clr_o);
  a_r11_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |=> mode_o == CH_RESET && !busoff_o && !recov_irq_o && !err_clr_o);
  a_r2_pol_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != CH_RESET |=> $stable(pol_q));
  a_r4_busoff_oper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busoff_o |-> mode_o == CH_OPER);
  a_r7_no_busoff_01: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_q == BOR_HALT_IN |-> !busoff_o);
  a_r10_irq_at_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recov_irq_o) |-> $past(busoff_o) && !busoff_o);
endmodule

// File: rtl/can_busoff_ctrl.sv
module can_busoff_ctrl
  import can_bor_pkg::*;
#(
  parameter int unsigned RUN_LEN = 11,
  parameter int unsigned OCC_LEN = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_vld_i,
  input  logic       bit_lvl_i,
  input  logic       busoff_enter_i,
  input  logic [1:0] rec_mode_i,
  input  logic       rec_mode_we_i,
  input  logic       halt_req_i,
  input  logic       reset_req_i,
  input  logic       run_req_i,
  output logic [1:0] chan_mode_o,
  output logic       busoff_o,
  output logic       recov_irq_o,
  output logic       err_clr_o
);
  logic     run_done, recov_done, busoff;
  ch_mode_e mode;

  can_bor_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(busoff),
    .bit_vld_i(bit_vld_i), .bit_lvl_i(bit_lvl_i), .run_done_o(run_done)
  );

  can_bor_occ_cnt #(.OCC_LEN(OCC_LEN)) u_occ (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(busoff),
    .run_done_i(run_done), .recov_done_o(recov_done)
  );

  can_bor_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .busoff_enter_i(busoff_enter_i),
    .recov_done_i(recov_done), .rec_mode_i(rec_mode_i),
    .rec_mode_we_i(rec_mode_we_i), .halt_req_i(halt_req_i),
    .reset_req_i(reset_req_i), .run_req_i(run_req_i), .mode_o(mode),
    .busoff_o(busoff), .recov_irq_o(recov_irq_o), .err_clr_o(err_clr_o)
  );

  assign chan_mode_o = mode;
  assign busoff_o    = busoff;
endmodule

// File: tb/can_busoff_ctrl_bench.sv
module can_busoff_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] M_OPER = 2'b00, M_RST = 2'b01, M_HALT = 2'b10;
  // [7]reset [6]halt [5]run [4]we [3:2]policy [1:0]expected mode
  localparam logic [7:0] VEC [8] = '{
    8'b0010_00_00, 8'b0100_00_10, 8'b0010_00_00, 8'b0001_01_00,
    8'b0110_00_10, 8'b1100_00_01, 8'b0100_00_10, 8'b1000_00_01
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bit_vld_i = 0, bit_lvl_i = 1, busoff_enter_i = 0, rec_mode_we_i = 0;
  logic halt_req_i = 0, reset_req_i = 0, run_req_i = 0;
  logic [1:0] rec_mode_i = 2'b00;
  logic [1:0] chan_mode_o;
  logic busoff_o, recov_irq_o, err_clr_o;
  int total = 0, bad = 0;
  bit fin = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  can_busoff_ctrl u_can_busoff_ctrl (.*);

  task automatic tick; @(negedge clk_i); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic lvl);
    bit_vld_i = 1; bit_lvl_i = lvl; tick(); bit_vld_i = 0;
  endtask

  task automatic send_runs(input int n);
    for (int i = 0; i < n * 11; i++) send_bit(1'b1);
  endtask

  task automatic req(input int which); // 0 reset 1 halt 2 run 3 enter
    case (which)
      0: reset_req_i = 1; 1: halt_req_i = 1; 2: run_req_i = 1; default: busoff_enter_i = 1;
    endcase
    tick();
    reset_req_i = 0; halt_req_i = 0; run_req_i = 0; busoff_enter_i = 0;
  endtask

  task automatic set_pol(input logic [1:0] p);
    rec_mode_i = p; rec_mode_we_i = 1; tick(); rec_mode_we_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1
    chk("R1 mode", chan_mode_o, M_RST);
    chk("R1 busoff", busoff_o, 0);
    chk("R1 irq/clr", {recov_irq_o, err_clr_o}, 0);
    rst_ni = 1; tick();

    // R3 table walk
    foreach (VEC[k]) begin
      reset_req_i = VEC[k][7]; halt_req_i = VEC[k][6]; run_req_i = VEC[k][5];
      rec_mode_we_i = VEC[k][4]; rec_mode_i = VEC[k][3:2];
      tick();
      reset_req_i = 0; halt_req_i = 0; run_req_i = 0; rec_mode_we_i = 0;
      chk($sformatf("R3 vec%0d", k), chan_mode_o, VEC[k][1:0]);
    end

    // R4/R2: policy write in operating was ignored, so entry gives bus-off
    req(2); req(3);
    chk("R4 busoff set", busoff_o, 1);
    chk("R2 policy kept 00", chan_mode_o, M_OPER);
    // R5: dominant restarts the run
    send_runs(127);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    tick();
    chk("R5 not yet recovered", busoff_o, 1);
    send_bit(1'b1); tick();
    chk("R6 busoff clear", busoff_o, 0);
    chk("R6 irq+clr", {recov_irq_o, err_clr_o}, 2'b11);
    chk("R6 mode oper", chan_mode_o, M_OPER);
    tick();
    chk("R12 pulses drop", {recov_irq_o, err_clr_o}, 0);

    // R6 deferred halt
    req(3); req(1);
    chk("R6 halt held", {chan_mode_o, busoff_o}, {M_OPER, 1'b1});
    send_runs(128); tick();
    chk("R6 halt at recovery", {chan_mode_o, busoff_o, recov_irq_o}, {M_HALT, 1'b0, 1'b1});

    // R7
    req(0); set_pol(2'b01); req(2); req(3);
    chk("R7 halt at entry", {chan_mode_o, busoff_o}, {M_HALT, 1'b0});
    chk("R7 clr no irq", {recov_irq_o, err_clr_o}, 2'b01);

    // R8
    req(0); set_pol(2'b10); req(2); req(3);
    send_runs(128); tick();
    chk("R8 halt+irq+clr", {chan_mode_o, busoff_o, recov_irq_o, err_clr_o}, {M_HALT, 3'b011});

    // R9
    req(0); set_pol(2'b11); req(2); req(3);
    send_runs(5); req(1);
    chk("R9 halt now", {chan_mode_o, busoff_o, recov_irq_o, err_clr_o}, {M_HALT, 3'b001});

    // R10
    req(2); req(3);
    send_runs(128); tick();
    chk("R10 irq oper", {chan_mode_o, busoff_o, recov_irq_o, err_clr_o}, {M_OPER, 3'b011});

    // R13: partial progress discarded on exit
    req(3); send_runs(60); req(0);
    chk("R13 reset exit", {chan_mode_o, busoff_o}, {M_RST, 1'b0});
    req(2); req(3); send_runs(127); tick();
    chk("R13 count restarted", busoff_o, 1);
    send_runs(1); tick();
    chk("R13 recovered", busoff_o, 0);

    // R11: reset coincides with recovery end under 10
    req(0); set_pol(2'b10); req(2); req(3);
    send_runs(128); req(0);
    chk("R11 recovery vs reset", {chan_mode_o, busoff_o, recov_irq_o, err_clr_o}, {M_RST, 3'b000});
    // R11: reset coincides with entry under 01
    set_pol(2'b01); req(2);
    busoff_enter_i = 1; reset_req_i = 1; tick(); busoff_enter_i = 0; reset_req_i = 0;
    chk("R11 entry vs reset", {chan_mode_o, busoff_o, recov_irq_o, err_clr_o}, {M_RST, 3'b000});

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule